// File: doc/BRIEF.md
# RFID Multi-Block Read Responder

This block serves a tag's range-read command. It takes the downlink bits one clock at a time, together with a strobe that marks the end of the frame. It checks the command code and the frame length, and it applies a configurable policy for the downlink CRC. When a command is accepted, it streams a response one bit per clock. The response is a start-of-frame marker, then the 32-bit contents of every block from the start address up to the end address, then a 16-bit uplink CRC.

The block array lives outside the block. It is reached through a synchronous read port that returns data one clock after the address. The responder presents each next address a full word ahead, so consecutive blocks follow each other without a gap. Its 6-bit addresses cover all 64 words of the array. An inverted range gets a short error response instead of data. A frame that fails the code, length or CRC rules gets no response at all.

Top module: `rfid_read_responder`

## Requirements
- R1: A command frame is 16 bits (4-bit code, 6-bit start address, 6-bit end address) or 32 bits (the same fields plus a 16-bit downlink CRC), all MSB first, and it ends with an `rxEnd` pulse after the last bit. Only code 4'b0001 is answered. Any other code or frame length gives no response.
- R2: The downlink CRC is CRC-16 with polynomial 0x1021, preset 0xFFFF and no final inversion, taken MSB first over the 12 address bits. With `crcRequired`=1, a frame without a CRC, or with a wrong CRC, gives no response.
- R3: With `crcRequired`=0, a 16-bit frame is accepted without a CRC. A 32-bit frame is still checked, and it is dropped silently if its CRC is wrong.
- R4: The response starts in the clock after the `rxEnd` edge with a start-of-frame. During the start-of-frame, `txSof`=1 and `txBit`=1 for `sofLen` clocks, with `sofLen` clamped to the range 3..10.
- R5: After the start-of-frame, blocks start..end are sent in ascending order, 32 bits each, MSB first. They go out one bit per clock with no gap between blocks.
- R6: After the data comes a 16-bit uplink CRC, MSB first. It uses the same algorithm as R2 from preset 0xFFFF. It covers the start address, the end address, the received downlink CRC when one was sent, and then all data bits.
- R7: If the end address is below the start address, the response is the start-of-frame followed by the 4-bit error code 4'b1110, MSB first, with no data and no CRC.
- R8: `txActive` is high for exactly the clocks of a response. `txLast` is high only on the final bit. While idle, `txBit`, `txSof` and `txLast` are 0.
- R9: Received bits and `rxEnd` pulses that arrive while a response is in progress are ignored. A later command is parsed normally.
- R10: After reset the block is idle, with every transmit output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit period per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| rxBit | input | 1 | Received command bit |
| rxValid | input | 1 | rxBit holds a valid bit this cycle |
| rxEnd | input | 1 | One-cycle strobe after the last bit of a frame |
| crcRequired | input | 1 | 1: downlink CRC mandatory; 0: checked only if present |
| sofLen | input | 4 | Start-of-frame length in clocks (clamped to 3..10) |
| memAddr | output | 6 | Block array read address |
| memRdata | input | 32 | Block array read data, one cycle after memAddr |
| txBit | output | 1 | Response bit |
| txActive | output | 1 | A response is being sent |
| txSof | output | 1 | Current bit belongs to the start-of-frame |
| txLast | output | 1 | Current bit is the last of the response |

## Verification
The read path is tried with a single block, a mid-array range sent with a correct CRC, the top two blocks, and the whole array. Together these separate the address order, the transitions between words, and whether the downlink CRC is folded into the uplink CRC. Frames with a wrong code, a wrong CRC under each policy setting, and a missing mandatory CRC must all stay silent, which separates the two CRC policies. An inverted range and extreme `sofLen` values probe the error path and the start-of-frame clamp. A command injected during a running response shows that the receiver is frozen while the block transmits.

// File: rtl/rfid_rd_pkg.sv
package rfid_rd_pkg;
  parameter int CMD_W    = 4;
  parameter int ADDR_W   = 6;
  parameter int WORD_W   = 32;
  parameter int CRC_W    = 16;
  parameter int SOFLEN_W = 4;

  parameter logic [CMD_W-1:0] READ_CODE = 4'b0001;
  parameter logic [CMD_W-1:0] ERR_CODE  = 4'b1110;
  parameter logic [CRC_W-1:0] CRC_POLY  = 16'h1021;
  parameter logic [CRC_W-1:0] CRC_INIT  = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SOF, ST_DATA, ST_CRC, ST_ERR
  } respState_t;

  typedef struct packed {
    logic rxEn;
    logic rxClear;
    logic startResp;
    logic loadWord;
    logic shiftData;
    logic shiftCrc;
    logic shiftErr;
  } ctrlStrobes_t;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/rfid_rd_datapath.sv
module rfid_rd_datapath
  import rfid_rd_pkg::*;
#(
  parameter int P_CMD_W  = CMD_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_WORD_W = WORD_W,
  parameter int P_CRC_W  = CRC_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobe,
  input  logic                rxBit,
  input  logic                rxValid,
  input  logic                crcRequired,
  input  logic [P_WORD_W-1:0] memRdata,
  output logic [P_ADDR_W-1:0] memAddr,
  output logic                cmdAccept,
  output logic                cmdRangeErr,
  output logic                lastWord,
  output logic                dataBit,
  output logic                crcBit,
  output logic                errBit
);
  localparam int FRAME_SHORT = P_CMD_W + 2 * P_ADDR_W;
  localparam int FRAME_LONG  = FRAME_SHORT + P_CRC_W;
  localparam int CNT_W       = $clog2(FRAME_LONG + 2);

  logic [FRAME_LONG-1:0] rxShift;
  logic [CNT_W-1:0]      rxCount;
  logic [P_CRC_W-1:0]    rxCrc;
  logic [P_ADDR_W-1:0]   startAddr, endAddr, wordAddr, fetchAddr;
  logic [P_WORD_W-1:0]   shiftReg;
  logic [P_CRC_W-1:0]    txCrc;
  logic [P_CMD_W-1:0]    errShift;

  logic                  isShort, isLong;
  logic [P_CMD_W-1:0]    decCode;
  logic [P_ADDR_W-1:0]   decStart, decEnd;
  logic                  crcOk;

  // Frame decode: field positions depend on whether a CRC trailer was sent
  always_comb begin
    isShort = (rxCount == CNT_W'(FRAME_SHORT));
    isLong  = (rxCount == CNT_W'(FRAME_LONG));
    if (isLong) begin
      decCode  = rxShift[FRAME_LONG-1 -: P_CMD_W];
      decStart = rxShift[P_CRC_W+2*P_ADDR_W-1 -: P_ADDR_W];
      decEnd   = rxShift[P_CRC_W+P_ADDR_W-1 -: P_ADDR_W];
      crcOk    = (rxCrc == '0);
    end else begin
      decCode  = rxShift[FRAME_SHORT-1 -: P_CMD_W];
      decStart = rxShift[2*P_ADDR_W-1 -: P_ADDR_W];
      decEnd   = rxShift[P_ADDR_W-1:0];
      crcOk    = !crcRequired;
    end
    cmdAccept   = (isShort || isLong) && (decCode == READ_CODE) && crcOk;
    cmdRangeErr = (decEnd < decStart);
  end

  // Receive side: the running CRC over post-code bits doubles as the uplink seed
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      rxCount <= '0;
      rxCrc   <= CRC_INIT;
    end else if (strobe.rxClear) begin
      rxCount <= '0;
      rxCrc   <= CRC_INIT;
    end else if (strobe.rxEn && rxValid) begin
      rxShift <= {rxShift[FRAME_LONG-2:0], rxBit};
      if (rxCount != '1) rxCount <= rxCount + 1'b1;
      if (rxCount >= CNT_W'(P_CMD_W)) rxCrc <= crcStep(rxCrc, rxBit);
    end
  end

  // Transmit side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr <= '0;
      endAddr   <= '0;
      wordAddr  <= '0;
      fetchAddr <= '0;
      shiftReg  <= '0;
      txCrc     <= CRC_INIT;
      errShift  <= '0;
    end else begin
      if (strobe.startResp) begin
        startAddr <= decStart;
        endAddr   <= decEnd;
        fetchAddr <= decStart;
        txCrc     <= rxCrc;
        errShift  <= ERR_CODE;
      end
      if (strobe.shiftData) begin
        shiftReg <= {shiftReg[P_WORD_W-2:0], 1'b0};
        txCrc    <= crcStep(txCrc, shiftReg[P_WORD_W-1]);
      end
      if (strobe.loadWord) begin
        shiftReg  <= memRdata;
        wordAddr  <= fetchAddr;
        fetchAddr <= fetchAddr + 1'b1;
      end
      if (strobe.shiftCrc) txCrc    <= {txCrc[P_CRC_W-2:0], 1'b0};
      if (strobe.shiftErr) errShift <= {errShift[P_CMD_W-2:0], 1'b0};
    end
  end

  assign memAddr  = fetchAddr;
  assign lastWord = (wordAddr == endAddr);
  assign dataBit  = shiftReg[P_WORD_W-1];
  assign crcBit   = txCrc[P_CRC_W-1];
  assign errBit   = errShift[P_CMD_W-1];

  // R9: receiver state does not move while control holds it frozen
  p_rx_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rxEn |=> $stable(rxShift) && $stable(rxCount));

  // R5: after a word load the fetch pointer is already one word ahead
  p_fetch_ahead_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadWord |=> (fetchAddr == wordAddr + 1'b1));

  // R1: a response is only started from a decoded, accepted command
  p_start_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startResp |-> (decCode == READ_CODE) && (isShort || isLong));
endmodule

// File: rtl/rfid_rd_control.sv
module rfid_rd_control
  import rfid_rd_pkg::*;
#(
  parameter int P_CMD_W    = CMD_W,
  parameter int P_WORD_W   = WORD_W,
  parameter int P_CRC_W    = CRC_W,
  parameter int P_SOFLEN_W = SOFLEN_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rxEnd,
  input  logic [P_SOFLEN_W-1:0] sofLen,
  input  logic                  cmdAccept,
  input  logic                  cmdRangeErr,
  input  logic                  lastWord,
  input  logic                  dataBit,
  input  logic                  crcBit,
  input  logic                  errBit,
  output ctrlStrobes_t          strobe,
  output logic                  txBit,
  output logic                  txActive,
  output logic                  txSof,
  output logic                  txLast
);
  localparam int CNT_W   = $clog2(P_WORD_W);
  localparam int SOF_MIN = 3;
  localparam int SOF_MAX = 10;

  respState_t              state;
  logic [CNT_W-1:0]        cnt;
  logic                    isErr;
  logic [P_SOFLEN_W-1:0]   sofEff;
  logic                    sofDone, wordDone, crcDone, errDone;

  always_comb begin
    if (sofLen < P_SOFLEN_W'(SOF_MIN))      sofEff = P_SOFLEN_W'(SOF_MIN);
    else if (sofLen > P_SOFLEN_W'(SOF_MAX)) sofEff = P_SOFLEN_W'(SOF_MAX);
    else                                    sofEff = sofLen;
    sofDone  = (cnt == CNT_W'(sofEff - 1'b1));
    wordDone = (cnt == CNT_W'(P_WORD_W - 1));
    crcDone  = (cnt == CNT_W'(P_CRC_W - 1));
    errDone  = (cnt == CNT_W'(P_CMD_W - 1));
  end

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE: begin
        strobe.rxEn      = 1'b1;
        strobe.rxClear   = rxEnd;
        strobe.startResp = rxEnd && cmdAccept;
      end
      ST_SOF:  strobe.loadWord = sofDone && !isErr;
      ST_DATA: begin
        strobe.shiftData = 1'b1;
        strobe.loadWord  = wordDone && !lastWord;
      end
      ST_CRC:  strobe.shiftCrc = 1'b1;
      ST_ERR:  strobe.shiftErr = 1'b1;
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      isErr <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (rxEnd && cmdAccept) begin
          state <= ST_SOF;
          cnt   <= '0;
          isErr <= cmdRangeErr;
        end
        ST_SOF: if (sofDone) begin
          cnt   <= '0;
          state <= isErr ? ST_ERR : ST_DATA;
        end else cnt <= cnt + 1'b1;
        ST_DATA: if (wordDone) begin
          cnt <= '0;
          if (lastWord) state <= ST_CRC;
        end else cnt <= cnt + 1'b1;
        ST_CRC: if (crcDone) begin
          cnt   <= '0;
          state <= ST_IDLE;
        end else cnt <= cnt + 1'b1;
        ST_ERR: if (errDone) begin
          cnt   <= '0;
          state <= ST_IDLE;
        end else cnt <= cnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    txActive = (state != ST_IDLE);
    txSof    = (state == ST_SOF);
    txLast   = (state == ST_CRC && crcDone) || (state == ST_ERR && errDone);
    unique case (state)
      ST_SOF:  txBit = 1'b1;
      ST_DATA: txBit = dataBit;
      ST_CRC:  txBit = crcBit;
      ST_ERR:  txBit = errBit;
      default: txBit = 1'b0;
    endcase
  end

  // R4: the start-of-frame is always followed by a body
  p_sof_then_body_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txSof) |-> txActive);

  // R8: the final bit ends the response
  p_last_ends_r8: assert property (@(posedge clk) disable iff (!rstN)
    txLast |=> !txActive);

  // R6: the CRC section is entered only from the data section
  p_crc_after_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CRC) |-> $past(state == ST_DATA || state == ST_CRC));

  // R7: an error response never touches the block array
  p_err_no_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    isErr && txActive |-> !strobe.loadWord);
endmodule

// File: rtl/rfid_read_responder.sv
module rfid_read_responder
  import rfid_rd_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxBit,
  input  logic                rxValid,
  input  logic                rxEnd,
  input  logic                crcRequired,
  input  logic [SOFLEN_W-1:0] sofLen,
  output logic [ADDR_W-1:0]   memAddr,
  input  logic [WORD_W-1:0]   memRdata,
  output logic                txBit,
  output logic                txActive,
  output logic                txSof,
  output logic                txLast
);
  ctrlStrobes_t strobe;
  logic cmdAccept, cmdRangeErr, lastWord, dataBit, crcBit, errBit;

  rfid_rd_datapath #(
    .P_CMD_W(CMD_W), .P_ADDR_W(ADDR_W), .P_WORD_W(WORD_W), .P_CRC_W(CRC_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxBit(rxBit), .rxValid(rxValid),
    .crcRequired(crcRequired), .memRdata(memRdata), .memAddr(memAddr),
    .cmdAccept(cmdAccept), .cmdRangeErr(cmdRangeErr), .lastWord(lastWord),
    .dataBit(dataBit), .crcBit(crcBit), .errBit(errBit)
  );

  rfid_rd_control #(
    .P_CMD_W(CMD_W), .P_WORD_W(WORD_W), .P_CRC_W(CRC_W), .P_SOFLEN_W(SOFLEN_W)
  ) i_control (
    .clk(clk), .rstN(rstN), .rxEnd(rxEnd), .sofLen(sofLen),
    .cmdAccept(cmdAccept), .cmdRangeErr(cmdRangeErr), .lastWord(lastWord),
    .dataBit(dataBit), .crcBit(crcBit), .errBit(errBit), .strobe(strobe),
    .txBit(txBit), .txActive(txActive), .txSof(txSof), .txLast(txLast)
  );
endmodule

// File: tb/test_rfid_read_responder.sv
module test_rfid_read_responder;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, rxBit, rxValid, rxEnd, crcRequired;
  logic [3:0] sofLen;
  logic [5:0] memAddr;
  logic [31:0] memRdata;
  logic txBit, txActive, txSof, txLast;

  logic [31:0] mem [64];
  always_ff @(posedge clk) memRdata <= mem[memAddr];

  rfid_read_responder i_rfid_read_responder (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .rxValid(rxValid), .rxEnd(rxEnd),
    .crcRequired(crcRequired), .sofLen(sofLen), .memAddr(memAddr),
    .memRdata(memRdata), .txBit(txBit), .txActive(txActive), .txSof(txSof),
    .txLast(txLast)
  );

  int total = 0, bad = 0;
  bit capBits [2300];
  bit capSof  [2300];
  bit capLast [2300];
  int capLen;
  bit expBits [2300];
  int expLen, expSofN;

  function automatic logic [15:0] benchCrc(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    c = {c[14:0], 1'b0};
    if (fb) c = c ^ 16'h1021;
    return c;
  endfunction

  function automatic logic [15:0] addrCrc(input logic [5:0] s, input logic [5:0] e);
    logic [15:0] c;
    logic [11:0] v;
    c = 16'hFFFF;
    v = {s, e};
    for (int i = 11; i >= 0; i--) c = benchCrc(c, v[i]);
    return c;
  endfunction

  function automatic int clampSof(input int l);
    return (l < 3) ? 3 : (l > 10) ? 10 : l;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [31:0] fr, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 1'b1;
      rxBit = fr[n-1-i];
    end
    @(negedge clk);
    rxValid = 1'b0;
    rxBit = 1'b0;
    rxEnd = 1'b1;
    @(negedge clk);
    rxEnd = 1'b0;
  endtask

  task automatic capture();
    capLen = 0;
    for (int k = 0; k < 2300; k++) begin
      if (!txActive) break;
      capBits[capLen] = txBit;
      capSof[capLen] = txSof;
      capLast[capLen] = txLast;
      capLen++;
      @(negedge clk);
    end
  endtask

  task automatic buildRead(input int s, input int e, input bit withDl, input logic [15:0] dl, input int sofL);
    logic [15:0] c;
    logic [5:0] sa, ea;
    expLen = 0;
    expSofN = clampSof(sofL);
    for (int i = 0; i < expSofN; i++) expBits[expLen++] = 1'b1;
    c = 16'hFFFF;
    sa = 6'(s);
    ea = 6'(e);
    for (int i = 5; i >= 0; i--) c = benchCrc(c, sa[i]);
    for (int i = 5; i >= 0; i--) c = benchCrc(c, ea[i]);
    if (withDl) for (int i = 15; i >= 0; i--) c = benchCrc(c, dl[i]);
    for (int a = s; a <= e; a++)
      for (int i = 31; i >= 0; i--) begin
        expBits[expLen++] = mem[a][i];
        c = benchCrc(c, mem[a][i]);
      end
    for (int i = 15; i >= 0; i--) expBits[expLen++] = c[i];
  endtask

  task automatic buildErr(input int sofL);
    logic [3:0] code;
    code = 4'b1110;
    expLen = 0;
    expSofN = clampSof(sofL);
    for (int i = 0; i < expSofN; i++) expBits[expLen++] = 1'b1;
    for (int i = 3; i >= 0; i--) expBits[expLen++] = code[i];
  endtask

  task automatic compareFrame(input string req);
    int mism, sofN, sofOk, lastN;
    mism = 0; sofN = 0; sofOk = 1; lastN = 0;
    check(capLen == expLen, req, "response length", capLen, expLen);
    for (int i = 0; i < capLen && i < expLen; i++) if (capBits[i] != expBits[i]) mism++;
    check(mism == 0, req, "bit mismatches", mism, 0);
    for (int i = 0; i < capLen; i++) begin
      if (capSof[i]) sofN++;
      if (capSof[i] != (i < expSofN)) sofOk = 0;
      if (capLast[i]) lastN++;
    end
    check(sofN == expSofN && sofOk == 1, "R4", "start-of-frame clocks", sofN, expSofN);
    check(lastN == 1 && capLen > 0 && capLast[capLen-1], "R8", "txLast count", lastN, 1);
  endtask

  task automatic expectSilent(input string req, input string what);
    int seen;
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      if (txActive || txBit || txSof || txLast) seen++;
      @(negedge clk);
    end
    check(seen == 0, req, what, seen, 0);
  endtask

  task automatic readTest(input int s, input int e, input bit withDl, input bit req, input int sofL, input string tag);
    logic [15:0] dl;
    crcRequired = req;
    sofLen = 4'(sofL);
    dl = addrCrc(6'(s), 6'(e));
    if (withDl) sendFrame({4'b0001, 6'(s), 6'(e), dl}, 32);
    else sendFrame({16'h0, 4'b0001, 6'(s), 6'(e)}, 16);
    capture();
    buildRead(s, e, withDl, dl, sofL);
    compareFrame(tag);
  endtask

  // R5 R6: single block, no downlink CRC
  task automatic tSingleBlock();
    readTest(7, 7, 1'b0, 1'b0, 3, "R5");
  endtask

  // R2 R6: range with correct CRC folded into uplink CRC
  task automatic tRangeWithCrc();
    readTest(5, 8, 1'b1, 1'b0, 10, "R6");
    readTest(62, 63, 1'b1, 1'b1, 6, "R2");
  endtask

  // R3: optional CRC present but wrong is dropped
  task automatic tOptionalBadCrc();
    crcRequired = 1'b0;
    sofLen = 4'd4;
    sendFrame({4'b0001, 6'd2, 6'd3, addrCrc(6'd2, 6'd3) ^ 16'h0100}, 32);
    expectSilent("R3", "response to wrong optional CRC");
  endtask

  // R2: mandatory CRC missing or wrong
  task automatic tMandatoryCrc();
    crcRequired = 1'b1;
    sofLen = 4'd4;
    sendFrame({16'h0, 4'b0001, 6'd1, 6'd2}, 16);
    expectSilent("R2", "response to missing mandatory CRC");
    sendFrame({4'b0001, 6'd1, 6'd2, addrCrc(6'd1, 6'd2) ^ 16'h0001}, 32);
    expectSilent("R2", "response to wrong mandatory CRC");
  endtask

  // R1: wrong code or length
  task automatic tBadFrames();
    crcRequired = 1'b0;
    sendFrame({16'h0, 4'b0010, 6'd1, 6'd2}, 16);
    expectSilent("R1", "response to wrong code");
    sendFrame({17'h0, 4'b0001, 6'd1, 5'd2}, 15);
    expectSilent("R1", "response to short frame");
  endtask

  // R7: inverted range
  task automatic tRangeErr();
    crcRequired = 1'b0;
    sofLen = 4'd5;
    sendFrame({16'h0, 4'b0001, 6'd9, 6'd4}, 16);
    capture();
    buildErr(5);
    compareFrame("R7");
  endtask

  // R4: start-of-frame clamp
  task automatic tSofClamp();
    readTest(0, 0, 1'b0, 1'b0, 1, "R4");
    readTest(10, 10, 1'b0, 1'b0, 15, "R4");
  endtask

  // R9: command during a response
  task automatic tBusyIgnore();
    logic [15:0] dl;
    crcRequired = 1'b0;
    sofLen = 4'd3;
    dl = addrCrc(6'd20, 6'd22);
    sendFrame({16'h0, 4'b0001, 6'd20, 6'd21}, 16);
    fork
      capture();
      begin
        repeat (5) @(negedge clk);
        sendFrame({4'b0001, 6'd20, 6'd22, dl}, 32);
      end
    join
    buildRead(20, 21, 1'b0, 16'h0, 3);
    compareFrame("R9");
    expectSilent("R9", "response to command sent while busy");
    readTest(30, 31, 1'b0, 1'b0, 3, "R9");
  endtask

  // R5: whole array, gapless across every word boundary
  task automatic tFullArray();
    readTest(0, 63, 1'b1, 1'b0, 3, "R5");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = (32'(i) * 32'h9E3779B9) ^ {26'h155AA3C, 6'(i)};
    rstN = 1'b0; rxBit = 1'b0; rxValid = 1'b0; rxEnd = 1'b0;
    crcRequired = 1'b0; sofLen = 4'd3;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!txActive && !txBit && !txSof && !txLast, "R10", "idle outputs after reset",
          {txActive, txBit, txSof, txLast}, 0);
    tSingleBlock();
    tRangeWithCrc();
    tOptionalBadCrc();
    tMandatoryCrc();
    tBadFrames();
    tRangeErr();
    tSofClamp();
    tBusyIgnore();
    tFullArray();
    expectSilent("R8", "idle outputs after last response");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule